// File: doc/BRIEF.md
# Dual Down-Counting System Timer

This block holds two independent 32-bit down-counters behind a small synchronous register port. Typically one counter runs free as a timekeeping source and the other produces one-shot or periodic tick interrupts. Each counter has its own enable, auto-reload enable, clock-source select and power-of-two prescaler. It also has a reload register, a directly writable live count and an event status bit that drives its interrupt line.

A counter decrements once per tick. A tick is either a prescaled fabric clock (one every 2^div fabric cycles) or a pulse on the fixed-reference tick-enable input. When a tick arrives while the count is already zero, the counter expires. In periodic mode it reloads from its reload register. In one-shot mode it stays at zero and raises no further events until software writes the count again. An expiry sets the counter's status bit. Writing zero to a status bit clears it, and writing one leaves it unchanged.

Top module: `dual_dn_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low.
- R2: Register offsets are: control 0x00, status 0x04, counter 0 reload 0x10 and count 0x14, counter 1 reload 0x18 and count 0x1C. Reload registers read back what was written. In control, counter 0 uses enable bit 0, reload-enable bit 1, reference-select bit 11 and prescaler bits 21:19. Counter 1 uses bits 2, 3, 12 and 24:22. All other control bits read 0.
- R3: With reference-select clear, an enabled counter decrements once every 2^div fabric clocks. The first decrement falls 2^div clocks after the enabling write.
- R4: With reference-select set, an enabled counter decrements only in cycles where the reference tick input is high.
- R5: A disabled counter holds its value, and its prescaler restarts from zero.
- R6: Writing a count register loads the counter directly, taking priority over a tick in the same cycle.
- R7: A counter expires on the tick that arrives while its count is zero. Expiry sets its status bit (bit 0 for counter 0, bit 8 for counter 1), and that counter's interrupt output is high while the bit is set.
- R8: With reload enabled, expiry loads the counter from its reload register and later expiries keep setting status.
- R9: With reload disabled, a counter raises one event after its count is written, then stays at zero with no further events.
- R10: A write to the status register clears each status bit whose written data bit is 0. Bits written as 1 are unchanged, so 0xFFFFFEFF clears only counter 1.
- R11: An expiry in the same cycle as a clearing status write leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | Fixed-reference tick enable, one cycle per reference tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 2 | Interrupt per counter, high while its status bit is set |

## Verification
A wrong count or a wrong prescaler phase shows up directly on a count-register read. The error appears within one prescaled period, and the bench compares each read against an arithmetic prediction from the start value, elapsed cycles and prescaler setting. A lost or extra expiry appears on irq_o within the same cycle of the expiring tick. The bench probes the cycle before and the cycle of the expected expiry, so an off-by-one in expiry timing or reload shows up at once. Errors in the status-bit priority only appear when a clearing write lands on the expiry cycle, so a directed case aligns exactly that cycle.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int NTMR   = 2;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 3;

    typedef struct packed {
        logic             en;
        logic             rl;
        logic             src;
        logic [DIV_W-1:0] div;
    } tmr_ctl_t;

    // bit positions inside the shared control word, per counter index
    function automatic int en_pos(int i);
        return 2 * i;
    endfunction
    function automatic int rl_pos(int i);
        return 2 * i + 1;
    endfunction
    function automatic int src_pos(int i);
        return 11 + i;
    endfunction
    function automatic int div_pos(int i);
        return 19 + DIV_W * i;
    endfunction
    function automatic int sts_pos(int i);
        return 8 * i;
    endfunction
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             src_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             ref_tick_i,
    output logic             tick_o
);
    localparam int PW = (1 << DIV_W) - 1;

    logic [PW-1:0] pcnt_d, pcnt_q;
    logic [PW-1:0] mask;
    logic [PW:0]   span;

    always_comb begin
        span   = (PW + 1)'(1) << div_i;
        mask   = PW'(span - (PW + 1)'(1));
        pcnt_d = en_i ? pcnt_q + PW'(1) : '0;
        tick_o = en_i && (src_i ? ref_tick_i : ((pcnt_q & mask) == mask));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R5
    presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pcnt_q == '0));

    // R5
    presc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !tick_o);
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rl_en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.cnt   = load_val_i;
            st_d.armed = 1'b1;
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                if (rl_en_i || st_q.armed) expire_o = 1'b1;
                if (rl_en_i) begin
                    st_d.cnt   = reload_i;
                    st_d.armed = 1'b1;
                end else begin
                    st_d.armed = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R6
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(load_val_i)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_o));

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && rl_en_i) |=> (cnt_o == $past(reload_i)));

    // R9
    oneshot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !rl_en_i) |=> !expire_o);
endmodule

// File: rtl/dual_dn_timer.sv
module dual_dn_timer
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [1:0]        irq_o
);
    localparam logic [ADDR_W-1:0] CTL_OFF = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] STS_OFF = ADDR_W'(8'h04);

    function automatic logic [ADDR_W-1:0] rld_off(int i);
        return ADDR_W'(8'h10 + 8 * i);
    endfunction
    function automatic logic [ADDR_W-1:0] val_off(int i);
        return ADDR_W'(8'h14 + 8 * i);
    endfunction

    typedef struct packed {
        tmr_ctl_t [NTMR-1:0]              ctl;
        logic     [NTMR-1:0][DATA_W-1:0]  rld;
        logic     [NTMR-1:0]              sts;
    } regs_t;

    regs_t r_d, r_q;

    logic [NTMR-1:0]             tick_w, expire_w, load_w;
    logic [NTMR-1:0][DATA_W-1:0] cnt_w;

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        dtmr_prescale #(.DIV_W(DIV_W)) u_presc (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (r_q.ctl[g].en),
            .src_i      (r_q.ctl[g].src),
            .div_i      (r_q.ctl[g].div),
            .ref_tick_i (ref_tick_i),
            .tick_o     (tick_w[g])
        );

        dtmr_counter #(.CNT_W(DATA_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_w[g]),
            .rl_en_i    (r_q.ctl[g].rl),
            .load_i     (load_w[g]),
            .load_val_i (wdata_i),
            .reload_i   (r_q.rld[g]),
            .cnt_o      (cnt_w[g]),
            .expire_o   (expire_w[g])
        );

        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire_w[g] |=> irq_o[g]);

        // R10
        clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_o[g]) |-> $past(wr_en_i && addr_i == STS_OFF
                                      && !wdata_i[sts_pos(g)]));
    end

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NTMR; i++) begin
            load_w[i] = wr_en_i && (addr_i == val_off(i));
            if (wr_en_i && addr_i == CTL_OFF) begin
                r_d.ctl[i].en  = wdata_i[en_pos(i)];
                r_d.ctl[i].rl  = wdata_i[rl_pos(i)];
                r_d.ctl[i].src = wdata_i[src_pos(i)];
                r_d.ctl[i].div = wdata_i[div_pos(i) +: DIV_W];
            end
            if (wr_en_i && addr_i == rld_off(i)) r_d.rld[i] = wdata_i;
            if (expire_w[i])
                r_d.sts[i] = 1'b1;
            else if (wr_en_i && addr_i == STS_OFF && !wdata_i[sts_pos(i)])
                r_d.sts[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NTMR; i++) begin
            if (addr_i == CTL_OFF) begin
                rdata_o[en_pos(i)]           = r_q.ctl[i].en;
                rdata_o[rl_pos(i)]           = r_q.ctl[i].rl;
                rdata_o[src_pos(i)]          = r_q.ctl[i].src;
                rdata_o[div_pos(i) +: DIV_W] = r_q.ctl[i].div;
            end
            if (addr_i == STS_OFF)    rdata_o[sts_pos(i)] = r_q.sts[i];
            if (addr_i == rld_off(i)) rdata_o = r_q.rld[i];
            if (addr_i == val_off(i)) rdata_o = cnt_w[i];
        end
    end

    assign irq_o = r_q.sts;
endmodule

// File: tb/tb_dual_dn_timer.sv
module tb_dual_dn_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [1:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    dual_dn_timer dut (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_count(logic [31:0] start, int waited, int div);
        return start - 32'(waited >> div);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; consumes exactly one posedge
    task automatic wr(logic [5:0] a, logic [31:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, start;
        int seed, div, w, t;
        seed = 1234;
        v = $urandom(seed);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        foreach (t_addrs[k]) begin
            rd(t_addrs[k], v);
            chk("R1 reset read", v, 0);
        end
        chk("R1 reset irq", 32'(irq_o), 0);

        // R2 control bit layout and reload readback
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v);
        chk("R2 ctrl readback", v, 32'h01F8_180F);
        wr(6'h00, 32'h0);
        wr(6'h10, 32'hA5A5_1234);
        wr(6'h18, 32'h0BAD_F00D);
        rd(6'h10, v); chk("R2 reload0", v, 32'hA5A5_1234);
        rd(6'h18, v); chk("R2 reload1", v, 32'h0BAD_F00D);
        wr(6'h04, 32'h0);

        // R3 random prescaled counting, R5 hold after disable
        for (int it = 0; it < 24; it++) begin
            t = it % 2;
            div = $urandom % 4;
            w = 5 + ($urandom % 60);
            start = $urandom | 32'h0001_0000;
            if (it == 0) start = 32'hFFFF_FFFF;
            wr(6'h00, 32'h0);
            wr(6'(8'h14 + 8 * t), start);
            wr(6'h00, (32'h1 << (2 * t)) | (32'(div) << (19 + 3 * t)));
            idle(w);
            rd(6'(8'h14 + 8 * t), v);
            chk("R3 prescaled count", v, exp_count(start, w, div));
            wr(6'h00, 32'h0);
            rd(6'(8'h14 + 8 * t), v);
            idle(10 + ($urandom % 10));
            rd(6'(8'h14 + 8 * t), v2);
            chk("R5 disabled hold", v2, v);
        end

        // R4 reference tick source
        wr(6'h14, 32'd100);
        wr(6'h00, 32'h0000_0801);
        idle(4);
        for (int p = 0; p < 5; p++) begin
            ref_tick_i = 1'b1; @(negedge clk);
            ref_tick_i = 1'b0; idle(3);
        end
        rd(6'h14, v);
        chk("R4 ref tick count", v, 32'd95);

        // R6 load while running overrides tick
        wr(6'h00, 32'h0000_0001);
        idle(3);
        wr(6'h14, 32'd50);
        rd(6'h14, v); chk("R6 direct load", v, 32'd50);
        idle(1);
        rd(6'h14, v); chk("R6 resumes", v, 32'd49);
        wr(6'h00, 32'h0);
        wr(6'h04, 32'h0);

        // R7 / R9 one-shot on counter 1, div 1, count 3: expiry 8 edges after enable
        wr(6'h1C, 32'd3);
        wr(6'h00, 32'h0040_0004);
        idle(7);
        chk("R7 no irq before expiry", 32'(irq_o[1]), 0);
        idle(1);
        chk("R7 irq at expiry", 32'(irq_o[1]), 1);
        rd(6'h04, v); chk("R7 status bit 8", v, 32'h0000_0100);
        wr(6'h04, 32'hFFFF_FEFF);
        idle(40);
        chk("R9 no second event", 32'(irq_o[1]), 0);
        rd(6'h1C, v); chk("R9 stays zero", v, 0);
        wr(6'h00, 32'h0);

        // R8 periodic on counter 0: reload 4, div 0
        wr(6'h10, 32'd4);
        wr(6'h14, 32'd4);
        wr(6'h00, 32'h0000_0003);
        idle(4);
        chk("R8 no early irq", 32'(irq_o[0]), 0);
        idle(1);
        chk("R8 first expiry", 32'(irq_o[0]), 1);
        rd(6'h14, v); chk("R8 reloaded", v, 32'd4);
        wr(6'h04, 32'hFFFF_FFFE);
        chk("R8 cleared", 32'(irq_o[0]), 0);
        idle(3);
        rd(6'h14, v); chk("R8 at zero", v, 0);
        idle(1);
        chk("R8 second expiry", 32'(irq_o[0]), 1);
        rd(6'h14, v); chk("R8 reloaded again", v, 32'd4);
        wr(6'h00, 32'h0);
        wr(6'h04, 32'h0);

        // R10 masked clear
        wr(6'h14, 32'd0);
        wr(6'h1C, 32'd0);
        wr(6'h00, 32'h0000_0005);
        idle(2);
        rd(6'h04, v); chk("R10 both set", v, 32'h0000_0101);
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, v); chk("R10 ones keep", v, 32'h0000_0101);
        wr(6'h04, 32'hFFFF_FEFF);
        rd(6'h04, v); chk("R10 only counter 1 cleared", v, 32'h0000_0001);
        wr(6'h04, 32'h0);
        rd(6'h04, v); chk("R10 all cleared", v, 0);
        wr(6'h00, 32'h0);

        // R11 set beats clear: count 2, div 0, expiry 3 edges after enable
        wr(6'h1C, 32'd2);
        wr(6'h00, 32'h0000_0004);
        idle(2);
        wr(6'h04, 32'h0);
        chk("R11 set wins", 32'(irq_o[1]), 1);
        wr(6'h04, 32'h0);
        chk("R11 later clear", 32'(irq_o[1]), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    logic [5:0] t_addrs [6] = '{6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C};
endmodule